// File: doc/BRIEF.md
# Adaptive-Threshold Edge Detector for a Low-Frequency Receive Path

The block turns a stream of 8-bit ADC samples, one per clock, into a clean digital edge signal. Each sample is smoothed by a multiplier-free low-pass IIR filter built from a chain of first-order sections. The filtered value feeds an envelope tracker that confirms a peak or a trough only once the signal has backed off from it by more than a programmable gap. The confirmed top and bottom of the envelope set four hysteresis levels: an upper trip, an upper re-arm, a lower re-arm and a lower trip.

A classifier compares the filtered value with these levels. It holds a polarity output and pulses for one cycle whenever it accepts a peak. A peak that repeats the direction of the previous one is still accepted, as long as the signal first went back past the matching re-arm level. The host sets the gap and reads the envelope and the levels for diagnostics. A gap of 127 is a sensible default.

Top module: `lf_edge_tracker`

## Requirements
- R1: While `rst` is high on a clock edge, and afterwards until the input moves, `env_max` is 255, `env_min` is 0, `edge_level` is 0 and `edge_pulse` is 0. The derived levels are therefore 192, 136, 119 and 63.
- R2: The filter has no overshoot. Once the input is held constant long enough, the filtered value equals that input exactly, so a held level becomes the value the envelope confirms.
- R3: A new `env_max` is taken from the running peak only when the filtered value drops below that peak by more than `env_gap`. A smaller pull-back leaves `env_max` unchanged.
- R4: A new `env_min` is taken from the running trough only when the filtered value rises above that trough by more than `env_gap`. A smaller rebound leaves `env_min` unchanged.
- R5: `env_max` is never below `env_min`.
- R6: With S = `env_max` − `env_min` and margin M (default 8), the four levels are computed as follows, each clipped to 0..255:
  - `thr_high` = max − S/4
  - `thr_high_hys` = max − S/2 + M
  - `thr_low_hys` = min + S/2 − M
  - `thr_low` = min + S/4
  - The divisions truncate.
- R7: `edge_level` becomes 1 when the filtered value exceeds `thr_high` and becomes 0 when it falls below `thr_low`. Otherwise it holds.
- R8: `edge_pulse` is high for exactly one cycle each time `edge_level` changes.
- R9: After a high peak, a further value above `thr_high` pulses `edge_pulse` without changing the level, provided the signal dropped below `thr_high_hys` in between. Low peaks behave the same way with `thr_low` and `thr_low_hys`.
- R10: A signal that stays beyond a trip level, with no return past the re-arm level, produces no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 8 | Raw ADC sample |
| env_gap | input | 8 | Pull-back distance needed to confirm a peak or a trough |
| env_max | output | 8 | Confirmed envelope top |
| env_min | output | 8 | Confirmed envelope bottom |
| thr_high | output | 8 | Upper trip level |
| thr_high_hys | output | 8 | Upper re-arm level |
| thr_low_hys | output | 8 | Lower re-arm level |
| thr_low | output | 8 | Lower trip level |
| edge_level | output | 1 | Detected polarity |
| edge_pulse | output | 1 | One-cycle flag for an accepted peak |

## Verification
The input is driven as a staircase of held levels. Because the filter has no overshoot, every segment settles to a known envelope, known levels and a known pulse count.

The staircase contains four kinds of movement:
- Alternating full swings, which separate real level changes from re-arm pulses.
- A partial dip followed by a second high peak, and the mirror of this with a low peak, which catch a detector that insists on alternation.
- A long hold above the upper trip, which catches a repeat pulse with no re-arm.
- Pull-backs smaller than the gap, which catch a tracker that confirms too early.

Separate runs near 0 and near 255 with a narrow span drive the re-arm levels into clipping.

// File: rtl/lfe_pkg.sv
package lfe_pkg;

    localparam int SMP_W = 8;

    typedef enum logic {
        SEEK_PEAK   = 1'b0,
        SEEK_TROUGH = 1'b1
    } trk_mode_e;

    typedef struct packed {
        logic [SMP_W-1:0] high;
        logic [SMP_W-1:0] high_hys;
        logic [SMP_W-1:0] low_hys;
        logic [SMP_W-1:0] low;
    } thr_set_t;

    // clip a signed intermediate into the unsigned sample range
    function automatic logic [SMP_W-1:0] clip_u(input logic signed [SMP_W+1:0] v);
        logic signed [SMP_W+1:0] top;
        top = $signed({2'b00, {SMP_W{1'b1}}});
        if (v < 0)
            return '0;
        else if (v > top)
            return '1;
        else
            return v[SMP_W-1:0];
    endfunction

endpackage

// File: rtl/lfe_iir_lowpass.sv
module lfe_iir_lowpass
    import lfe_pkg::*;
#(
    parameter int FRAC_W   = 8,
    parameter int ALPHA_SH = 2,
    parameter int STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] x_in,
    output logic [SMP_W-1:0] y_out
);
    localparam int ACC_W = SMP_W + FRAC_W;
    localparam int DIF_W = ACC_W + 2;

    logic [ACC_W-1:0] st_q  [STAGES];
    logic [ACC_W-1:0] st_in [STAGES];

    // each section: acc += (in - acc) >>> ALPHA_SH, floor rounding
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [ACC_W-1:0]        acc_q;
        logic signed [DIF_W-1:0] dlt;

        if (g == 0) begin : g_head
            assign st_in[g] = {x_in, {FRAC_W{1'b0}}};
        end else begin : g_chain
            assign st_in[g] = st_q[g-1];
        end

        assign dlt = $signed({2'b00, st_in[g]}) - $signed({2'b00, acc_q});

        always_ff @(posedge clk) begin
            if (rst)
                acc_q <= '0;
            else
                acc_q <= ACC_W'($signed({2'b00, acc_q}) + (dlt >>> ALPHA_SH));
        end

        assign st_q[g] = acc_q;
    end

    logic [ACC_W:0] rnd;
    assign rnd   = {1'b0, st_q[STAGES-1]} + (ACC_W+1)'(1 << (FRAC_W-1));
    assign y_out = rnd[ACC_W] ? '1 : rnd[ACC_W-1:FRAC_W];

endmodule

// File: rtl/lfe_envelope_tracker.sv
module lfe_envelope_tracker
    import lfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] f_in,
    input  logic [SMP_W-1:0] gap_in,
    output logic [SMP_W-1:0] env_max,
    output logic [SMP_W-1:0] env_min
);
    trk_mode_e        mode_q;
    logic [SMP_W-1:0] cand_q, max_q, min_q;
    logic             fall_far, rise_far;

    assign fall_far = ({1'b0, f_in} + {1'b0, gap_in}) < {1'b0, cand_q};
    assign rise_far = {1'b0, f_in} > ({1'b0, cand_q} + {1'b0, gap_in});

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SEEK_PEAK;
            cand_q <= '0;
            max_q  <= '1;
            min_q  <= '0;
        end else begin
            unique case (mode_q)
                SEEK_PEAK: begin
                    if (fall_far) begin
                        max_q  <= cand_q;
                        mode_q <= SEEK_TROUGH;
                        cand_q <= f_in;
                    end else if (f_in > cand_q) begin
                        cand_q <= f_in;
                    end
                end
                SEEK_TROUGH: begin
                    if (rise_far) begin
                        min_q  <= cand_q;
                        mode_q <= SEEK_PEAK;
                        cand_q <= f_in;
                    end else if (f_in < cand_q) begin
                        cand_q <= f_in;
                    end
                end
                default: mode_q <= SEEK_PEAK;
            endcase
        end
    end

    assign env_max = max_q;
    assign env_min = min_q;

    // R5
    env_order_chk: assert property (@(posedge clk) disable iff (rst)
        max_q >= min_q);

    // R3
    max_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (max_q != $past(max_q)) |-> (mode_q == SEEK_TROUGH && $past(mode_q) == SEEK_PEAK));

    // R4
    min_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (min_q != $past(min_q)) |-> (mode_q == SEEK_PEAK && $past(mode_q) == SEEK_TROUGH));

endmodule

// File: rtl/lfe_threshold_gen.sv
module lfe_threshold_gen
    import lfe_pkg::*;
#(
    parameter int HYS_MARGIN = 8
) (
    input  logic [SMP_W-1:0] env_max,
    input  logic [SMP_W-1:0] env_min,
    output thr_set_t         thr
);
    localparam logic signed [SMP_W+1:0] MARG = (SMP_W+2)'(HYS_MARGIN);

    logic [SMP_W-1:0]        span;
    logic signed [SMP_W+1:0] mx, mn, qtr, hlf;

    always_comb begin
        span = (env_max >= env_min) ? (env_max - env_min) : '0;
        mx   = $signed({2'b00, env_max});
        mn   = $signed({2'b00, env_min});
        qtr  = $signed({2'b00, span >> 2});
        hlf  = $signed({2'b00, span >> 1});
        thr.high     = clip_u(mx - qtr);
        thr.high_hys = clip_u(mx - hlf + MARG);
        thr.low_hys  = clip_u(mn + hlf - MARG);
        thr.low      = clip_u(mn + qtr);
    end

endmodule

// File: rtl/lfe_edge_classifier.sv
module lfe_edge_classifier
    import lfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] f_in,
    input  thr_set_t         thr,
    output logic             level,
    output logic             pulse
);
    logic arm_hi_q, arm_lo_q;
    logic above_hi, below_lo;

    assign above_hi = f_in > thr.high;
    assign below_lo = f_in < thr.low;

    always_ff @(posedge clk) begin
        if (rst) begin
            level    <= 1'b0;
            pulse    <= 1'b0;
            arm_hi_q <= 1'b0;
            arm_lo_q <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (f_in < thr.high_hys) arm_hi_q <= 1'b1;
            if (f_in > thr.low_hys)  arm_lo_q <= 1'b1;
            if (above_hi) begin
                if (!level || arm_hi_q) pulse <= 1'b1;
                level    <= 1'b1;
                arm_hi_q <= 1'b0;
            end else if (below_lo) begin
                if (level || arm_lo_q) pulse <= 1'b1;
                level    <= 1'b0;
                arm_lo_q <= 1'b0;
            end
        end
    end

    // R8
    flip_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |-> pulse);

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R7
    rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(level) |-> $past(above_hi));

    // R7
    fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(level) |-> $past(below_lo));

endmodule

// File: rtl/lf_edge_tracker.sv
module lf_edge_tracker
    import lfe_pkg::*;
#(
    parameter int FRAC_W     = 8,
    parameter int ALPHA_SH   = 2,
    parameter int STAGES     = 2,
    parameter int HYS_MARGIN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] smp_in,
    input  logic [SMP_W-1:0] env_gap,
    output logic [SMP_W-1:0] env_max,
    output logic [SMP_W-1:0] env_min,
    output logic [SMP_W-1:0] thr_high,
    output logic [SMP_W-1:0] thr_high_hys,
    output logic [SMP_W-1:0] thr_low_hys,
    output logic [SMP_W-1:0] thr_low,
    output logic             edge_level,
    output logic             edge_pulse
);
    logic [SMP_W-1:0] filt;
    thr_set_t         thr;

    lfe_iir_lowpass #(
        .FRAC_W  (FRAC_W),
        .ALPHA_SH(ALPHA_SH),
        .STAGES  (STAGES)
    ) u_lpf (
        .clk  (clk),
        .rst  (rst),
        .x_in (smp_in),
        .y_out(filt)
    );

    lfe_envelope_tracker u_env (
        .clk    (clk),
        .rst    (rst),
        .f_in   (filt),
        .gap_in (env_gap),
        .env_max(env_max),
        .env_min(env_min)
    );

    lfe_threshold_gen #(
        .HYS_MARGIN(HYS_MARGIN)
    ) u_thr (
        .env_max(env_max),
        .env_min(env_min),
        .thr    (thr)
    );

    lfe_edge_classifier u_cls (
        .clk  (clk),
        .rst  (rst),
        .f_in (filt),
        .thr  (thr),
        .level(edge_level),
        .pulse(edge_pulse)
    );

    assign thr_high     = thr.high;
    assign thr_high_hys = thr.high_hys;
    assign thr_low_hys  = thr.low_hys;
    assign thr_low      = thr.low;

    // R6
    thr_order_chk: assert property (@(posedge clk) disable iff (rst)
        thr.high >= thr.low);

endmodule

// File: tb/sim_lf_edge_tracker.sv
module sim_lf_edge_tracker;

    typedef struct packed {
        logic [7:0]  smp;
        logic [7:0]  gap;
        logic [15:0] hold;
        logic [7:0]  mx;
        logic [7:0]  mn;
        logic [7:0]  hi;
        logic [7:0]  hz;
        logic [7:0]  lz;
        logic [7:0]  lo;
        logic        lvl;
        logic [3:0]  np;
    } seg_t;

    localparam int NSEG = 11;
    // columns: sample, gap, hold, max, min, high, high_hys, low_hys, low, level, pulses
    localparam seg_t SEGS [NSEG] = '{
        '{8'd200, 8'd20, 16'd150, 8'd255, 8'd0,   8'd192, 8'd136, 8'd119, 8'd63,  1'b1, 4'd1}, // R7 R8 first rise
        '{8'd40,  8'd20, 16'd150, 8'd200, 8'd0,   8'd150, 8'd108, 8'd92,  8'd50,  1'b0, 4'd1}, // R2 R3 R7 fall
        '{8'd200, 8'd20, 16'd150, 8'd200, 8'd40,  8'd160, 8'd128, 8'd112, 8'd80,  1'b1, 4'd1}, // R4 R6 rise
        '{8'd120, 8'd20, 16'd150, 8'd200, 8'd40,  8'd160, 8'd128, 8'd112, 8'd80,  1'b1, 4'd0}, // R9 partial dip, no pulse
        '{8'd200, 8'd20, 16'd150, 8'd200, 8'd120, 8'd180, 8'd168, 8'd152, 8'd140, 1'b1, 4'd1}, // R9 repeated high peak
        '{8'd200, 8'd20, 16'd60,  8'd200, 8'd120, 8'd180, 8'd168, 8'd152, 8'd140, 1'b1, 4'd0}, // R10 held above trip
        '{8'd190, 8'd20, 16'd150, 8'd200, 8'd120, 8'd180, 8'd168, 8'd152, 8'd140, 1'b1, 4'd0}, // R3 small pull-back
        '{8'd40,  8'd20, 16'd150, 8'd200, 8'd120, 8'd180, 8'd168, 8'd152, 8'd140, 1'b0, 4'd1}, // R7 fall
        '{8'd55,  8'd20, 16'd150, 8'd200, 8'd120, 8'd180, 8'd168, 8'd152, 8'd140, 1'b0, 4'd0}, // R4 small rebound
        '{8'd150, 8'd20, 16'd150, 8'd200, 8'd40,  8'd160, 8'd128, 8'd112, 8'd80,  1'b0, 4'd0}, // R4 R9 partial rise
        '{8'd40,  8'd40, 16'd150, 8'd150, 8'd40,  8'd123, 8'd103, 8'd87,  8'd67,  1'b0, 4'd1}  // R9 repeated low peak
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] smp_in = 8'd0;
    logic [7:0] env_gap = 8'd20;
    logic [7:0] env_max, env_min, thr_high, thr_high_hys, thr_low_hys, thr_low;
    logic       edge_level, edge_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    int dbl = 0;
    int ord_bad = 0;
    bit prev_pulse = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lf_edge_tracker u0 (
        .clk         (clk),
        .rst         (rst),
        .smp_in      (smp_in),
        .env_gap     (env_gap),
        .env_max     (env_max),
        .env_min     (env_min),
        .thr_high    (thr_high),
        .thr_high_hys(thr_high_hys),
        .thr_low_hys (thr_low_hys),
        .thr_low     (thr_low),
        .edge_level  (edge_level),
        .edge_pulse  (edge_pulse)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (edge_pulse) pulses++;
            if (edge_pulse && prev_pulse) dbl++;
            if (env_max < env_min) ord_bad++;
            prev_pulse = edge_pulse;
        end else begin
            prev_pulse = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_in = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic hold_level(input logic [7:0] s, input logic [7:0] g, input int cyc);
        smp_in = s;
        env_gap = g;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic chk_levels(input string tag, input int hi, input int hz, input int lz, input int lo);
        chk(thr_high == hi,     tag, thr_high,     hi);
        chk(thr_high_hys == hz, tag, thr_high_hys, hz);
        chk(thr_low_hys == lz,  tag, thr_low_hys,  lz);
        chk(thr_low == lo,      tag, thr_low,      lo);
    endtask

    initial begin
        #(10 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int p0;
        // R1 reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(env_max == 8'd255, "R1 max", env_max, 255);
        chk(env_min == 8'd0,   "R1 min", env_min, 0);
        chk(edge_level == 1'b0, "R1 level", edge_level, 0);
        chk(edge_pulse == 1'b0, "R1 pulse", edge_pulse, 0);
        chk_levels("R1 R6 levels", 192, 136, 119, 63);

        // staircase walk: R2 R3 R4 R6 R7 R9 R10
        for (int i = 0; i < NSEG; i++) begin
            p0 = pulses;
            hold_level(SEGS[i].smp, SEGS[i].gap, int'(SEGS[i].hold));
            chk(env_max == SEGS[i].mx, "R2 R3 max", env_max, SEGS[i].mx);
            chk(env_min == SEGS[i].mn, "R2 R4 min", env_min, SEGS[i].mn);
            chk_levels("R6 levels", SEGS[i].hi, SEGS[i].hz, SEGS[i].lz, SEGS[i].lo);
            chk(edge_level == SEGS[i].lvl, "R7 level", edge_level, SEGS[i].lvl);
            chk(pulses - p0 == int'(SEGS[i].np), "R8 R9 R10 pulses", pulses - p0, SEGS[i].np);
        end

        // R6 clipping at the top: max 255, min 249
        do_reset();
        hold_level(8'd255, 8'd5, 150);
        hold_level(8'd249, 8'd5, 150);
        hold_level(8'd255, 8'd5, 150);
        chk(env_max == 8'd255, "R2 R3 top max", env_max, 255);
        chk(env_min == 8'd249, "R2 R4 top min", env_min, 249);
        chk_levels("R6 top clip", 254, 255, 244, 250);

        // R6 clipping at the bottom: max 6, min 0
        do_reset();
        hold_level(8'd6, 8'd5, 150);
        hold_level(8'd0, 8'd5, 150);
        hold_level(8'd6, 8'd5, 150);
        chk(env_max == 8'd6, "R2 R3 bottom max", env_max, 6);
        chk(env_min == 8'd0, "R2 R4 bottom min", env_min, 0);
        chk_levels("R6 bottom clip", 5, 11, 0, 1);

        chk(dbl == 0,     "R8 pulse width", dbl, 0);
        chk(ord_bad == 0, "R5 ordering", ord_bad, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule